// File: doc/BRIEF.md
# Stepped Soft-Start Reference Generator

This block produces the digital reference code that a voltage-mode regulation loop tracks while a converter starts up. After a start strobe the code climbs from zero to a fixed target in equal increments, one increment per programmable number of clock ticks. When the final increment lands, the block raises a completion flag. An abort input covers overcurrent shutdown and disable. It returns the block to rest at once, and a later start strobe begins a fresh ramp. This gives the hiccup retry a simple restart point.

The block also decides when the power switches may start to toggle. A digitized measurement of the present output voltage, on the same scale as the reference, is compared with the ramp. While the output already sits at or above the ramp value, switching stays off, so a pre-charged output is never pulled down during the climb. Switching is enabled once the ramp rises strictly above the measured output. If the output never falls below the ramp, switching is enabled when the ramp completes. After switching is enabled it stays on until the block is aborted or restarted.

Top module: `softstart_ref`

## Requirements
- R1: During and right after reset, the reference code, the switching-enable flag and the done flag are all zero.
- R2: After a start strobe is sampled, the reference holds 0 for STEP_TICKS cycles. It then rises by TARGET_CODE/NUM_STEPS once every STEP_TICKS cycles and never exceeds TARGET_CODE.
- R3: The done flag rises exactly NUM_STEPS*STEP_TICKS cycles after the start strobe is sampled, with the reference equal to TARGET_CODE. Both hold until an abort or a new start.
- R4: With a measured output code of 0, switching-enable rises in the cycle after the first step.
- R5: With a measured output below the target, switching-enable stays low while the reference is less than or equal to the measured code. It rises one cycle after the reference becomes strictly greater.
- R6: With a measured output at or above the target, switching-enable stays low for the whole ramp and rises in the same cycle as the done flag.
- R7: Once switching-enable is high, later changes of the measured output do not lower it. Only an abort or a new start lowers it.
- R8: An abort sampled on a clock edge sets the reference to 0 and clears switching-enable and done by the next cycle. The block then stays at rest. An abort wins over a start strobe sampled on the same edge.
- R9: A start strobe that arrives while the ramp is in progress has no effect on the reference, the done timing or switching-enable.
- R10: A start strobe sampled while the block is at rest or done restarts the ramp from zero, with done and switching-enable cleared in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, begins a ramp from rest or done |
| abort_i | input | 1 | Abort (overcurrent or disable), returns the block to rest |
| vout_code_i | input | REF_W | Digitized output voltage, same scale as the reference |
| ref_code_o | output | REF_W | Soft-start reference code |
| sw_en_o | output | 1 | Power switches may toggle |
| done_o | output | 1 | Ramp has reached the target |

## Verification
The embedded properties check on every cycle that an abort empties all three outputs by the next edge. They check that done only appears with the reference at target and switching enabled, and that switching-enable never drops without an abort or restart. They also check that it only rises after the ramp has passed the measured output or has ended, and that the reference and tick counter hold still between steps. The exact step schedule, the count of cycles to completion, the cycle on which switching starts for a given pre-bias, and the fact that a stray start in mid-ramp changes nothing can only be shown by the bench. The bench compares every cycle of whole ramps against a cycle-level model for several output levels.

// File: rtl/softstart_pkg.sv
package softstart_pkg;

   typedef enum logic [1:0] {
      SS_IDLE = 2'd0,
      SS_RAMP = 2'd1,
      SS_DONE = 2'd2
   } ss_state_e;

endpackage

// File: rtl/ss_step_timer.sv
module ss_step_timer #(
   parameter int unsigned STEP_TICKS = 5300
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   input  logic clr_i,
   output logic step_o
);

   localparam int unsigned CNT_W = (STEP_TICKS > 1) ? $clog2(STEP_TICKS) : 1;

   generate
      if (STEP_TICKS == 1) begin : g_direct
         assign step_o = run_i & ~clr_i;
      end else begin : g_count
         localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_TICKS - 1);
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               cnt_q <= '0;
            end else if (clr_i) begin
               cnt_q <= '0;
            end else if (run_i) begin
               cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            end
         end

         assign step_o = run_i & ~clr_i & (cnt_q == LAST);

         // R2
         cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!run_i && !clr_i) |=> $stable(cnt_q));

         // R2
         cnt_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            step_o |=> (cnt_q == '0));
      end
   endgenerate

endmodule

// File: rtl/ss_ramp_accum.sv
module ss_ramp_accum #(
   parameter int unsigned REF_W       = 10,
   parameter int unsigned NUM_STEPS   = 64,
   parameter int unsigned TARGET_CODE = 640
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             step_i,
   output logic [REF_W-1:0] ref_o,
   output logic             last_o
);

   localparam int unsigned STEP_CODE = TARGET_CODE / NUM_STEPS;
   localparam logic [REF_W-1:0] STEP_V = REF_W'(STEP_CODE);
   localparam logic [REF_W-1:0] TGT_V  = REF_W'(TARGET_CODE);
   localparam logic [REF_W-1:0] PRE_V  = REF_W'(TARGET_CODE - STEP_CODE);

   logic [REF_W-1:0] ref_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ref_q <= '0;
      end else if (clr_i) begin
         ref_q <= '0;
      end else if (step_i) begin
         ref_q <= ref_q + STEP_V;
      end
   end

   assign ref_o  = ref_q;
   assign last_o = step_i & (ref_q == PRE_V);

   // R2
   ref_ceiling_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ref_q <= TGT_V);

   // R2
   ref_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!step_i && !clr_i) |=> $stable(ref_q));

endmodule

// File: rtl/ss_bias_gate.sv
module ss_bias_gate #(
   parameter int unsigned REF_W = 10
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             ramp_i,
   input  logic             end_i,
   input  logic [REF_W-1:0] ref_i,
   input  logic [REF_W-1:0] vout_i,
   output logic             en_o
);

   logic en_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q <= 1'b0;
      end else if (clr_i) begin
         en_q <= 1'b0;
      end else if (ramp_i && (end_i || (ref_i > vout_i))) begin
         en_q <= 1'b1;
      end
   end

   assign en_o = en_q;

   // R5
   en_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(en_q) |-> (($past(ref_i) > $past(vout_i)) || $past(end_i)));

   // R7
   en_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_q && !clr_i) |=> en_q);

endmodule

// File: rtl/softstart_ref.sv
module softstart_ref
   import softstart_pkg::*;
#(
   parameter int unsigned REF_W       = 10,
   parameter int unsigned NUM_STEPS   = 64,
   parameter int unsigned TARGET_CODE = 640,
   parameter int unsigned STEP_TICKS  = 5300
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic             abort_i,
   input  logic [REF_W-1:0] vout_code_i,
   output logic [REF_W-1:0] ref_code_o,
   output logic             sw_en_o,
   output logic             done_o
);

   localparam logic [REF_W-1:0] TGT_V = REF_W'(TARGET_CODE);

   generate
      if (NUM_STEPS < 2) begin : g_bad_steps
         $error("softstart_ref: NUM_STEPS must be at least 2");
      end
      if (STEP_TICKS < 1) begin : g_bad_ticks
         $error("softstart_ref: STEP_TICKS must be at least 1");
      end
      if ((TARGET_CODE % NUM_STEPS) != 0) begin : g_bad_div
         $error("softstart_ref: TARGET_CODE must be a multiple of NUM_STEPS");
      end
      if (REF_W < 2 || REF_W > 30) begin : g_bad_width
         $error("softstart_ref: REF_W out of range");
      end else if (TARGET_CODE >= (32'd1 << REF_W)) begin : g_bad_target
         $error("softstart_ref: TARGET_CODE does not fit in REF_W bits");
      end
   endgenerate

   ss_state_e state_q;
   logic      launch;
   logic      clr;
   logic      in_ramp;
   logic      step_p;
   logic      ramp_last;
   logic [REF_W-1:0] ref_w;
   logic      en_w;

   assign launch  = start_i & ~abort_i & (state_q != SS_RAMP);
   assign clr     = launch | abort_i;
   assign in_ramp = (state_q == SS_RAMP);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= SS_IDLE;
      end else if (abort_i) begin
         state_q <= SS_IDLE;
      end else if (launch) begin
         state_q <= SS_RAMP;
      end else if (in_ramp && ramp_last) begin
         state_q <= SS_DONE;
      end
   end

   ss_step_timer #(
      .STEP_TICKS (STEP_TICKS)
   ) u_timer (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (in_ramp),
      .clr_i  (clr),
      .step_o (step_p)
   );

   ss_ramp_accum #(
      .REF_W       (REF_W),
      .NUM_STEPS   (NUM_STEPS),
      .TARGET_CODE (TARGET_CODE)
   ) u_accum (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr),
      .step_i (step_p),
      .ref_o  (ref_w),
      .last_o (ramp_last)
   );

   ss_bias_gate #(
      .REF_W (REF_W)
   ) u_gate (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr),
      .ramp_i (in_ramp),
      .end_i  (ramp_last),
      .ref_i  (ref_w),
      .vout_i (vout_code_i),
      .en_o   (en_w)
   );

   assign ref_code_o = ref_w;
   assign sw_en_o    = en_w;
   assign done_o     = (state_q == SS_DONE);

   // R8
   abort_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      abort_i |=> ((ref_code_o == '0) && !sw_en_o && !done_o));

   // R3
   done_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> ((ref_code_o == TGT_V) && sw_en_o));

   // R9
   ramp_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_ramp && !abort_i && !ramp_last) |=> (state_q == SS_RAMP));

   // R10
   launch_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      launch |=> ((ref_code_o == '0) && !done_o && !sw_en_o));

endmodule

// File: tb/softstart_ref_test.sv
module softstart_ref_test;

   localparam int W    = 10;
   localparam int NS   = 64;
   localparam int TGT  = 640;
   localparam int TK   = 4;
   localparam int STEP = TGT / NS;
   localparam int RAMP_CYC = NS * TK;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic abort = 1'b0;
   logic [W-1:0] vout = '0;
   logic [W-1:0] ref_code;
   logic sw_en;
   logic done;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   softstart_ref #(
      .REF_W       (W),
      .NUM_STEPS   (NS),
      .TARGET_CODE (TGT),
      .STEP_TICKS  (TK)
   ) uut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .start_i     (start),
      .abort_i     (abort),
      .vout_code_i (vout),
      .ref_code_o  (ref_code),
      .sw_en_o     (sw_en),
      .done_o      (done)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Whole ramp against a cycle model. sw_req names the enable rule tested.
   task automatic run_ramp(input int v0, input int v1, input int change_at,
                           input int restart_at, input string sw_req);
      bit hit;
      int st;
      int er;
      int ed;
      @(negedge clk);
      vout  = W'(v0);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      hit = 1'b0;
      for (int k = 0; k <= RAMP_CYC + 3; k++) begin
         st = k / TK;
         if (st > NS) st = NS;
         er = st * STEP;
         ed = (k >= RAMP_CYC) ? 1 : 0;
         if (k == 0) check("R10 restart ref", int'(ref_code), 0);
         check("R2 ref", int'(ref_code), er);
         check("R3 done", int'(done), ed);
         check(sw_req, int'(sw_en), (ed == 1 || hit) ? 1 : 0);
         if (k == change_at) vout = W'(v1);
         start = (k == restart_at) ? 1'b1 : 1'b0;
         if (er > int'(vout)) hit = 1'b1;
         @(negedge clk);
      end
      start = 1'b0;
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      check("R1 ref", int'(ref_code), 0);
      check("R1 sw_en", int'(sw_en), 0);
      check("R1 done", int'(done), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 ref after release", int'(ref_code), 0);
      check("R1 done after release", int'(done), 0);
   endtask

   task automatic t_abort();
      @(negedge clk);
      vout  = '0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (100) @(negedge clk);
      check("R8 mid-ramp sw_en", int'(sw_en), 1);
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      check("R8 ref", int'(ref_code), 0);
      check("R8 sw_en", int'(sw_en), 0);
      check("R8 done", int'(done), 0);
      repeat (3 * TK) @(negedge clk);
      check("R8 stays idle ref", int'(ref_code), 0);
      check("R8 stays idle sw_en", int'(sw_en), 0);
   endtask

   task automatic t_abort_priority();
      @(negedge clk);
      start = 1'b1;
      abort = 1'b1;
      @(negedge clk);
      start = 1'b0;
      abort = 1'b0;
      repeat (3 * TK) @(negedge clk);
      check("R8 priority ref", int'(ref_code), 0);
      check("R8 priority done", int'(done), 0);
   endtask

   task automatic t_done_abort();
      check("R3 done held", int'(done), 1);
      @(negedge clk);
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      check("R8 done cleared", int'(done), 0);
      check("R8 ref cleared", int'(ref_code), 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      run_ramp(0, 0, -1, -1, "R4 sw_en");
      run_ramp(0, 0, -1, -1, "R10 sw_en");
      t_done_abort();
      run_ramp(300, 1023, 200, -1, "R5,R7 sw_en");
      run_ramp(299, 299, -1, -1, "R5 sw_en edge");
      run_ramp(700, 700, -1, -1, "R6 sw_en");
      run_ramp(640, 640, -1, -1, "R6 sw_en at target");
      t_abort();
      run_ramp(0, 0, -1, 77, "R9 sw_en");
      t_abort_priority();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule